// File: doc/BRIEF.md
# Serial presence-detect write-protect controller

This block guards the 512-byte array of a two-page serial presence-detect memory against unwanted writes. The array is split into four 128-byte quarters, and each quarter has its own protect flag. The flag index is formed from the page bit and the most significant byte-address bit. The block sits behind a bit-level I2C slave front end. It sees only byte-level events: a START or repeated START pulse, a STOP pulse, and each received byte together with a strobe. For every received byte it returns a one-cycle ACK or NACK decision. For memory writes it also raises a write-enable pulse with the full 9-bit target address.

Protect flags can be queried, set or cleared only through a separate device-select group. The block accepts these commands only while the high-voltage detector on the A0 pin is active. The detector level passes through a configurable synchronizer first. A query returns no data: the flag state is given by the acknowledge of the device-select byte. A set or clear command needs two dummy bytes and takes effect only at a clean STOP.

Top module: `spd_wp_ctrl`

## Requirements
- R1: After reset the four flags equal FLAG_INIT (all clear by default), and rsp_vld, rsp_ack and wr_en are low.
- R2: Each byte strobe produces exactly one rsp_vld pulse on the following cycle. rsp_ack=1 means ACK and 0 means NACK. rsp_ack is low whenever rsp_vld is low.
- R3: In a device-select byte, upper nibble 4'b1010 selects the memory and 4'b0110 selects the protect commands. Any other nibble is NACKed, and every byte up to the next START is also NACKed.
- R4: A protect device-select byte is ACKed only if the synchronized detector level was high at the START and has stayed high since. Otherwise it is NACKed.
- R5: Bits 3:1 of a protect device-select byte pick the target: 001 flag 0, 100 flag 1, 101 flag 2, 000 flag 3, and 011 (writes only) clear-all. Every other code is NACKed. Code 011 with bit 0 set is also NACKed.
- R6: A query (bit 0 = 1) is ACKed when the selected flag is clear and NACKed when it is set. No flag changes, and later bytes up to the next START are NACKed.
- R7: A set or clear (bit 0 = 0) ACKs two dummy bytes and NACKs any further byte. It changes the flags only at a STOP that directly follows the second dummy byte. A repeated START, a missing dummy byte or an extra byte leaves the flags unchanged. The new flag values are visible from the cycle after the STOP.
- R8: If the synchronized detector level is low at any cycle between the START and the STOP cycle, inclusive, the set or clear is void.
- R9: A set command raises exactly one flag. A clear command lowers all four flags.
- R10: For a memory write, the byte-address byte is ACKed. Each data byte targets flag index {page_sel, address bit 7}. If that flag is clear, the byte is ACKed, wr_en pulses with wr_addr={page_sel, address}, and the address advances by one, wrapping within 256. If the flag is set, the byte is NACKed, wr_en stays low, and later bytes are NACKed.
- R11: A memory device-select byte with bit 0 = 1 is ACKed and changes no state of this block. Later bytes are NACKed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_start | input | 1 | One-cycle pulse for START or repeated START |
| ev_stop | input | 1 | One-cycle pulse for STOP |
| ev_byte | input | 1 | One-cycle strobe: byte_dat holds a received byte |
| byte_dat | input | 8 | Received byte, read/write bit in bit 0 of device-select bytes |
| page_sel | input | 1 | Current page of the array |
| hv_det | input | 1 | High-voltage detector level on A0, asynchronous |
| rsp_vld | output | 1 | Acknowledge decision valid |
| rsp_ack | output | 1 | 1 = ACK, 0 = NACK |
| wr_en | output | 1 | Write-enable pulse for one array byte |
| wr_addr | output | 9 | Array address of the write, page bit on top |

## Verification
On every cycle, the embedded properties check four things: the one-cycle response timing, that flags change only at a STOP with the detector window still valid, that a set raises at most one flag while any fall clears all of them, and that no write-enable ever targets a protected quarter. Other behaviour is visible only through the bench's stimulus sequences compared against its behavioural model. This covers the command encoding, the count of dummy bytes, aborts by repeated START or a short command, a detector drop in the middle of a command, query answers, and address wrap across a quarter boundary.

// File: rtl/spd_wp_pkg.sv
package spd_wp_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEVSEL,
      ST_MADDR,
      ST_MDATA,
      ST_PDUM1,
      ST_PDUM2,
      ST_PARMED
   } wp_seq_t;

   localparam logic [2:0] CODE_CLR_ALL = 3'b011;

   // returns {valid, flag index}
   function automatic logic [2:0] code_slot(input logic [2:0] code);
      case (code)
         3'b001:  code_slot = {1'b1, 2'd0};
         3'b100:  code_slot = {1'b1, 2'd1};
         3'b101:  code_slot = {1'b1, 2'd2};
         3'b000:  code_slot = {1'b1, 2'd3};
         default: code_slot = 3'b000;
      endcase
   endfunction

endpackage

// File: rtl/wp_hv_window.sv
module wp_hv_window #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ev_start,
   input  logic hv_det,
   output logic hv_win
);
   logic hv_s;
   logic hv_ok_q;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign hv_s = hv_det;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= SYNC_STAGES'({sh_q, hv_det});
         end
         assign hv_s = sh_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        hv_ok_q <= 1'b0;
      else if (ev_start) hv_ok_q <= hv_s;
      else               hv_ok_q <= hv_ok_q & hv_s;
   end

   assign hv_win = hv_ok_q & hv_s;

endmodule

// File: rtl/wp_flag_bank.sv
module wp_flag_bank #(
   parameter int NUM_BLK = 4,
   parameter logic [NUM_BLK-1:0] FLAG_INIT = '0,
   localparam int IDX_W = $clog2(NUM_BLK)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_stb,
   input  logic [IDX_W-1:0]   set_idx,
   input  logic               clr_stb,
   output logic [NUM_BLK-1:0] flags
);
   generate
      for (genvar g = 0; g < NUM_BLK; g++) begin : g_flag
         logic fl_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       fl_q <= FLAG_INIT[g];
            else if (clr_stb) fl_q <= 1'b0;
            else if (set_stb && set_idx == IDX_W'(g)) fl_q <= 1'b1;
         end
         assign flags[g] = fl_q;
      end
   endgenerate

   // R9: set and clear never arrive together
   AST_SET_CLR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(set_stb && clr_stb)); // R9

endmodule

// File: rtl/wp_seq.sv
module wp_seq
   import spd_wp_pkg::*;
#(
   parameter int MEM_AW = 8,
   parameter int NUM_BLK = 4,
   parameter logic [3:0] MEM_GRP = 4'b1010,
   parameter logic [3:0] PRT_GRP = 4'b0110,
   localparam int IDX_W = $clog2(NUM_BLK)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ev_start,
   input  logic               ev_stop,
   input  logic               ev_byte,
   input  logic [7:0]         byte_dat,
   input  logic               page_sel,
   input  logic               hv_win,
   input  logic [NUM_BLK-1:0] flags,
   output logic               rsp_vld,
   output logic               rsp_ack,
   output logic               wr_en,
   output logic [MEM_AW:0]    wr_addr,
   output logic               set_stb,
   output logic [IDX_W-1:0]   set_idx,
   output logic               clr_stb
);
   wp_seq_t            st_q, st_n;
   logic [MEM_AW-1:0]  adr_q, adr_n;
   logic [2:0]         code_q, code_n;
   logic               rv_n, ra_n, we_n;
   logic [MEM_AW:0]    wa_n;
   logic [2:0]         dev_slot, arm_slot;
   logic [IDX_W-1:0]   mem_blk;

   assign dev_slot = code_slot(byte_dat[3:1]);
   assign arm_slot = code_slot(code_q);
   assign mem_blk  = {page_sel, adr_q[MEM_AW-1]};

   always_comb begin
      st_n    = st_q;
      adr_n   = adr_q;
      code_n  = code_q;
      rv_n    = 1'b0;
      ra_n    = 1'b0;
      we_n    = 1'b0;
      wa_n    = wr_addr;
      set_stb = 1'b0;
      clr_stb = 1'b0;
      set_idx = arm_slot[IDX_W-1:0];
      if (ev_start) begin
         st_n = ST_DEVSEL;
      end else if (ev_stop) begin
         if (st_q == ST_PARMED && hv_win) begin
            if (code_q == CODE_CLR_ALL) clr_stb = 1'b1;
            else                        set_stb = arm_slot[2];
         end
         st_n = ST_IDLE;
      end else if (ev_byte) begin
         rv_n = 1'b1;
         st_n = ST_IDLE;
         case (st_q)
            ST_DEVSEL: begin
               if (byte_dat[7:4] == MEM_GRP) begin
                  ra_n = 1'b1;
                  if (!byte_dat[0]) st_n = ST_MADDR;
               end else if (byte_dat[7:4] == PRT_GRP && hv_win) begin
                  if (byte_dat[0]) begin
                     if (dev_slot[2]) ra_n = !flags[dev_slot[IDX_W-1:0]];
                  end else if (dev_slot[2] || byte_dat[3:1] == CODE_CLR_ALL) begin
                     ra_n   = 1'b1;
                     code_n = byte_dat[3:1];
                     st_n   = ST_PDUM1;
                  end
               end
            end
            ST_MADDR: begin
               ra_n  = 1'b1;
               adr_n = byte_dat[MEM_AW-1:0];
               st_n  = ST_MDATA;
            end
            ST_MDATA: begin
               if (!flags[mem_blk]) begin
                  ra_n  = 1'b1;
                  we_n  = 1'b1;
                  wa_n  = {page_sel, adr_q};
                  adr_n = adr_q + 1'b1;
                  st_n  = ST_MDATA;
               end
            end
            ST_PDUM1: begin
               ra_n = 1'b1;
               st_n = ST_PDUM2;
            end
            ST_PDUM2: begin
               ra_n = 1'b1;
               st_n = ST_PARMED;
            end
            default: st_n = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         adr_q   <= '0;
         code_q  <= '0;
         rsp_vld <= 1'b0;
         rsp_ack <= 1'b0;
         wr_en   <= 1'b0;
         wr_addr <= '0;
      end else begin
         st_q    <= st_n;
         adr_q   <= adr_n;
         code_q  <= code_n;
         rsp_vld <= rv_n;
         rsp_ack <= ra_n;
         wr_en   <= we_n;
         wr_addr <= wa_n;
      end
   end

   AST_RSP_FOLLOWS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      ev_byte |=> rsp_vld); // R2
   AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !ev_byte |=> (!rsp_vld && !rsp_ack)); // R2
   AST_WE_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (rsp_vld && rsp_ack)); // R10

endmodule

// File: rtl/spd_wp_ctrl.sv
module spd_wp_ctrl #(
   parameter int MEM_AW = 8,
   parameter int PAGE_W = 1,
   parameter int HV_SYNC = 2,
   parameter logic [3:0] MEM_GRP = 4'b1010,
   parameter logic [3:0] PRT_GRP = 4'b0110,
   parameter logic [3:0] FLAG_INIT = 4'b0000
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ev_start,
   input  logic            ev_stop,
   input  logic            ev_byte,
   input  logic [7:0]      byte_dat,
   input  logic            page_sel,
   input  logic            hv_det,
   output logic            rsp_vld,
   output logic            rsp_ack,
   output logic            wr_en,
   output logic [MEM_AW:0] wr_addr
);
   localparam int NUM_BLK = 2 ** (PAGE_W + 1);
   localparam int IDX_W   = $clog2(NUM_BLK);

   generate
      if (NUM_BLK != 4 || MEM_AW < 2 || MEM_AW > 8 || HV_SYNC < 0) begin : g_bad_cfg
         $error("spd_wp_ctrl: unsupported configuration");
      end
   endgenerate

   logic               hv_win;
   logic [NUM_BLK-1:0] flags;
   logic               set_stb, clr_stb;
   logic [IDX_W-1:0]   set_idx;

   wp_hv_window #(.SYNC_STAGES(HV_SYNC)) i_hv (
      .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .hv_det(hv_det), .hv_win(hv_win)
   );

   wp_flag_bank #(.NUM_BLK(NUM_BLK), .FLAG_INIT(FLAG_INIT)) i_flags (
      .clk(clk), .rst_n(rst_n), .set_stb(set_stb), .set_idx(set_idx),
      .clr_stb(clr_stb), .flags(flags)
   );

   wp_seq #(.MEM_AW(MEM_AW), .NUM_BLK(NUM_BLK), .MEM_GRP(MEM_GRP), .PRT_GRP(PRT_GRP)) i_seq (
      .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
      .ev_byte(ev_byte), .byte_dat(byte_dat), .page_sel(page_sel),
      .hv_win(hv_win), .flags(flags), .rsp_vld(rsp_vld), .rsp_ack(rsp_ack),
      .wr_en(wr_en), .wr_addr(wr_addr), .set_stb(set_stb), .set_idx(set_idx),
      .clr_stb(clr_stb)
   );

   AST_CHG_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (flags != $past(flags)) |-> $past(ev_stop)); // R7
   AST_CHG_NEEDS_HV: assert property (@(posedge clk) disable iff (!rst_n)
      (flags != $past(flags)) |-> $past(hv_win)); // R8
   AST_SET_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(flags & ~$past(flags)) <= 1); // R9
   AST_CLR_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(flags) & ~flags)) |-> (flags == '0)); // R9
   AST_NO_PROT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !flags[{wr_addr[MEM_AW], wr_addr[MEM_AW-1]}]); // R10

endmodule

// File: tb/test_spd_wp_ctrl.sv
module test_spd_wp_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int HV_SYNC = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ev_start = 1'b0, ev_stop = 1'b0, ev_byte = 1'b0;
   logic [7:0] byte_dat = 8'h00;
   logic       page_sel = 1'b0, hv_det = 1'b0;
   logic       rsp_vld, rsp_ack, wr_en;
   logic [8:0] wr_addr;

   int total = 0, bad = 0;
   bit done = 0;

   spd_wp_ctrl #(.HV_SYNC(HV_SYNC)) i_spd_wp_ctrl (
      .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
      .ev_byte(ev_byte), .byte_dat(byte_dat), .page_sel(page_sel),
      .hv_det(hv_det), .rsp_vld(rsp_vld), .rsp_ack(rsp_ack),
      .wr_en(wr_en), .wr_addr(wr_addr)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(string tag, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   bit   hq [0:7];
   int   ph;
   bit   mfl [0:3];
   bit   mwin;
   int   madr;
   int   mcode;
   bit   e_vld, e_ack, e_we;
   int   e_wa;

   function automatic int flag_of(int c);
      case (c)
         1: return 0;
         4: return 1;
         5: return 2;
         0: return 3;
         default: return -1;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (hq[i]) hq[i] = 0;
         ph = 0; mwin = 0; madr = 0; mcode = 0;
         foreach (mfl[i]) mfl[i] = 0;
         e_vld = 0; e_ack = 0; e_we = 0; e_wa = 0;
      end else begin
         bit hv_now, live;
         int f, b;
         if (HV_SYNC == 0) hv_now = hv_det;
         else begin
            hv_now = hq[HV_SYNC-1];
            for (int i = HV_SYNC-1; i > 0; i--) hq[i] = hq[i-1];
            hq[0] = hv_det;
         end
         live = mwin && hv_now;
         e_vld = 0; e_ack = 0; e_we = 0;
         if (ev_start) begin
            ph = 1;
         end else if (ev_stop) begin
            if (ph == 6 && live) begin
               if (mcode == 3) foreach (mfl[i]) mfl[i] = 0;
               else mfl[flag_of(mcode)] = 1;
            end
            ph = 0;
         end else if (ev_byte) begin
            b = byte_dat;
            e_vld = 1;
            case (ph)
               1: begin
                  ph = 0;
                  f = flag_of((b >> 1) & 7);
                  if ((b >> 4) == 4'hA) begin
                     e_ack = 1;
                     if (b % 2 == 0) ph = 2;
                  end else if ((b >> 4) == 4'h6 && live) begin
                     if (b % 2 == 1) begin
                        if (f >= 0) e_ack = !mfl[f];
                     end else if (f >= 0 || ((b >> 1) & 7) == 3) begin
                        e_ack = 1; mcode = (b >> 1) & 7; ph = 4;
                     end
                  end
               end
               2: begin e_ack = 1; madr = b; ph = 3; end
               3: begin
                  if (mfl[page_sel * 2 + madr / 128]) ph = 0;
                  else begin
                     e_ack = 1; e_we = 1;
                     e_wa = page_sel * 256 + madr;
                     madr = (madr + 1) % 256;
                  end
               end
               4: begin e_ack = 1; ph = 5; end
               5: begin e_ack = 1; ph = 6; end
               default: ph = 0;
            endcase
         end
         mwin = ev_start ? hv_now : live;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R2 rsp_vld", rsp_vld, e_vld);
         chk("R2 rsp_ack", rsp_ack, e_ack);
         chk("R10 wr_en", wr_en, e_we);
         if (e_we) chk("R10 wr_addr", wr_addr, e_wa);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask
   task automatic go_start();
      ev_start = 1; @(negedge clk); ev_start = 0;
   endtask
   task automatic go_stop();
      ev_stop = 1; @(negedge clk); ev_stop = 0;
   endtask
   task automatic xfer(input logic [7:0] b, output int a);
      ev_byte = 1; byte_dat = b; @(negedge clk); ev_byte = 0;
      a = rsp_ack;
   endtask
   task automatic set_hv(bit v);
      hv_det = v; tick(HV_SYNC + 2);
   endtask
   task automatic query(input logic [2:0] code, output int a);
      go_start(); xfer({4'b0110, code, 1'b1}, a); go_stop(); tick(1);
   endtask
   task automatic setclr(input logic [2:0] code, output int a);
      int a1, a2;
      go_start(); xfer({4'b0110, code, 1'b0}, a); xfer(8'h00, a1); xfer(8'h00, a2);
      go_stop(); tick(1);
      a = a & a1 & a2;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int a;
      tick(3);
      chk("R1 rsp_vld in reset", rsp_vld, 0);
      chk("R1 wr_en in reset", wr_en, 0);
      rst_n = 1; tick(1);
      chk("R1 rsp_ack after reset", rsp_ack, 0);
      set_hv(1);
      query(3'b001, a); chk("R1 flag0 clear", a, 1);
      query(3'b100, a); chk("R1 flag1 clear", a, 1);
      query(3'b101, a); chk("R1 flag2 clear", a, 1);
      query(3'b000, a); chk("R1 flag3 clear", a, 1);

      // R11 memory read select, R3 foreign group
      go_start(); xfer(8'hA1, a); chk("R11 read select ack", a, 1);
      xfer(8'h00, a); chk("R11 later byte nack", a, 0); go_stop(); tick(1);
      go_start(); xfer(8'h52, a); chk("R3 foreign nack", a, 0);
      xfer(8'hA0, a); chk("R3 stays nack", a, 0); go_stop(); tick(1);

      // R10 unprotected write crossing quarter boundary
      page_sel = 0;
      go_start(); xfer(8'hA0, a); chk("R10 dev ack", a, 1);
      xfer(8'h7E, a); chk("R10 addr ack", a, 1);
      xfer(8'h11, a); chk("R10 data0 wr_addr", wr_addr, 9'h07E);
      xfer(8'h22, a); chk("R10 data1 wr_addr", wr_addr, 9'h07F);
      xfer(8'h33, a); chk("R10 data2 wr_addr", wr_addr, 9'h080);
      chk("R10 data2 wr_en", wr_en, 1);
      go_stop(); tick(1);

      // R5 R9 set flag1, R6 query
      setclr(3'b100, a); chk("R5 set flag1 acks", a, 1);
      query(3'b100, a); chk("R6 flag1 set nack", a, 0);
      query(3'b001, a); chk("R6 flag0 clear ack", a, 1);

      // R10 protected quarter, then other page
      go_start(); xfer(8'hA0, a); xfer(8'h90, a);
      xfer(8'h55, a); chk("R10 protected nack", a, 0);
      chk("R10 protected no wr_en", wr_en, 0);
      xfer(8'h56, a); chk("R10 later nack", a, 0); go_stop(); tick(1);
      page_sel = 1;
      go_start(); xfer(8'hA0, a); xfer(8'h90, a);
      xfer(8'h57, a); chk("R10 page1 ack", a, 1);
      chk("R10 page1 wr_addr", wr_addr, 9'h190);
      go_stop(); tick(1);
      page_sel = 0;

      // R5 undefined codes
      go_start(); xfer(8'h6E, a); chk("R5 code 111 nack", a, 0); go_stop(); tick(1);
      query(3'b011, a); chk("R5 query of clear code nack", a, 0);

      // R4 no detector level
      set_hv(0);
      go_start(); xfer(8'h62, a); chk("R4 no hv nack", a, 0);
      xfer(8'h00, a); xfer(8'h00, a); go_stop(); tick(1);
      go_start(); set_hv(1); xfer(8'h62, a); chk("R4 hv after start nack", a, 0);
      go_stop(); tick(1);
      query(3'b001, a); chk("R4 flag0 unchanged", a, 1);

      // R8 detector drop inside command
      go_start(); xfer(8'h62, a); xfer(8'h00, a); xfer(8'h00, a);
      set_hv(0); set_hv(1); go_stop(); tick(1);
      query(3'b001, a); chk("R8 void after drop", a, 1);

      // R7 aborts
      go_start(); xfer(8'h62, a); xfer(8'h00, a);
      go_start(); xfer(8'hA1, a); go_stop(); tick(1);
      query(3'b001, a); chk("R7 restart abort", a, 1);
      go_start(); xfer(8'h62, a); xfer(8'h00, a); go_stop(); tick(1);
      query(3'b001, a); chk("R7 missing byte", a, 1);
      go_start(); xfer(8'h62, a); xfer(8'h00, a); xfer(8'h00, a);
      xfer(8'h00, a); chk("R7 extra byte nack", a, 0); go_stop(); tick(1);
      query(3'b001, a); chk("R7 extra byte no change", a, 1);

      // R9 set one, clear all
      setclr(3'b000, a);
      query(3'b000, a); chk("R9 flag3 set", a, 0);
      query(3'b100, a); chk("R9 flag1 still set", a, 0);
      query(3'b101, a); chk("R9 flag2 untouched", a, 1);
      setclr(3'b011, a); chk("R9 clear acks", a, 1);
      query(3'b100, a); chk("R9 flag1 cleared", a, 1);
      query(3'b000, a); chk("R9 flag3 cleared", a, 1);

      tick(2);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule